// File: doc/BRIEF.md
# Packet-mode receive FIFO and link-layer read port

This block sits on the physical-layer side of a packet-over-SONET receiver. Framing logic writes packet words into it. Each word is 32 data bits tagged with start-of-packet, end-of-packet, a 2-bit count of unused trailing bytes and an error flag. The words are held in a 64-entry FIFO. A link-layer device pulls them out through a read port clocked by the reference clock it supplies. The port has an active-low read enable. When the enable is sampled low, the output registers are refreshed on the next edge, so the link layer samples them at the end of the cycle after the one in which it asserted the enable.

The read port presents data, start and end markers, a modulo field, odd parity and an error flag, all qualified by a valid output. The valid output drops when the FIFO runs dry or after the last word of a packet has been handed over. Once low, it stays low until the port is deselected through the `sel` input for at least one cycle. No words leave the FIFO while valid is low.

The write side raises a one-cycle arrival pulse for every start-of-packet word it accepts, so that external logic can time FIFO latency against the read-side start marker. Words offered while the FIFO is full are discarded, and a sticky overflow flag records that this happened.

The read controller has four states:
- **ST_IDLE**: the port is deselected.
- **ST_XFER**: words may be popped.
- **ST_EOP**: an end-of-packet word is on the outputs.
- **ST_HOLD**: valid is latched low.

Its transitions are:
- **deselect**: any state goes to ST_IDLE when `sel` is low.
- **reselect**: ST_IDLE goes to ST_XFER.
- **eop_pop**: ST_XFER goes to ST_EOP when an end-of-packet word is popped.
- **dry**: ST_XFER goes to ST_HOLD on an enabled cycle with the FIFO empty.
- **eop_done**: ST_EOP goes to ST_HOLD on the next enabled cycle.

Top module: `pos_rx_port`

## Requirements
- R1: After reset, `rd_val`, `arr_ts` and `ovf_sticky` are 0 and the FIFO is empty.
- R2: If `rd_enb_n` is sampled low at clock edge k while the port is transferring and the FIFO holds a word, the next word appears on the outputs with `rd_val`=1 after edge k+1, and not before.
- R3: `rd_par` makes the total count of ones over `rd_data` and `rd_par` odd.
- R4: `rd_err` is 1 only on a word that has `rd_eop`=1; a stored error tag on a non-EOP word is presented as 0.
- R5: An enabled read with the FIFO empty drives `rd_val` to 0, and it stays 0 while `sel` stays high, even after new words arrive.
- R6: On the first enabled cycle after an end-of-packet word has been presented, `rd_val` goes to 0 and stays 0 while `sel` stays high.
- R7: No word is removed from the FIFO while `rd_val` is low; after reselection, reading resumes with the next unread word in write order.
- R8: While `rd_enb_n` was high in the previous cycle and `sel` is high, all read outputs keep their values.
- R9: `arr_ts` is 1 for exactly the cycle after each accepted write whose start-of-packet tag is 1.
- R10: A write offered while 64 words are stored is discarded and sets `ovf_sticky`, which remains 1 until reset.
- R11: Holding `sel` low for one cycle clears the latched-low valid condition; the cycle after `sel` returns high the port accepts read enables again.
- R12: `rd_mod` carries the stored unused-byte count (0 = all four bytes valid) on EOP words and reads 0 on all other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-layer reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | 32 | Word to store |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_mod | input | 2 | Unused trailing bytes on an EOP word |
| wr_err | input | 1 | Packet aborted or FCS failed |
| arr_ts | output | 1 | One-cycle pulse per accepted start-of-packet word |
| ovf_sticky | output | 1 | A write was dropped because the FIFO was full |
| sel | input | 1 | Port selected when high |
| rd_enb_n | input | 1 | Active-low read enable |
| rd_data | output | 32 | Read data word |
| rd_sop | output | 1 | Read word starts a packet |
| rd_eop | output | 1 | Read word ends a packet |
| rd_mod | output | 2 | Unused trailing bytes, EOP words only |
| rd_par | output | 1 | Odd parity over `rd_data` |
| rd_err | output | 1 | Packet error, EOP words only |
| rd_val | output | 1 | Read outputs are valid |

## Verification
The bench checks the one-cycle read latency right after the enable first falls; a design that pops on the same edge would present the word a cycle early. After an EOP word and after a read from an empty FIFO it keeps the enable low and later writes new data. A port that fails to latch valid low would hand out words of the next packet, or lose them, before deselection. It fills the FIFO past 64 words and then streams all of it back, which exposes an overwritten head or a missing overflow flag. Error and modulo tags are placed on middle words, so a design that does not mask them shows them outside EOP words.

// File: rtl/pos_rx_pkg.sv
package pos_rx_pkg;
    localparam int DATA_W = 32;
    localparam int MOD_W  = 2;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [MOD_W-1:0]  mod;
        logic              err;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    localparam int WORD_W = $bits(rx_word_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_EOP  = 2'd2,
        ST_HOLD = 2'd3
    } rd_state_t;
endpackage

// File: rtl/pos_rx_fifo.sv
module pos_rx_fifo
    import pos_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t din,
    input  logic     pop,
    output rx_word_t head,
    output logic     full,
    output logic     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push;
    logic            do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_pop_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/pos_rx_parity.sv
module pos_rx_parity #(
    parameter int W = 32
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);
    assign odd_bit = ~(^data);
endmodule

// File: rtl/pos_rx_rdctl.sv
module pos_rx_rdctl
    import pos_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              enb_n_i,
    input  logic              fifo_empty,
    input  rx_word_t          head,
    input  logic              head_par,
    output logic              pop,
    output logic [DATA_W-1:0] data_o,
    output logic              sop_o,
    output logic              eop_o,
    output logic [MOD_W-1:0]  mod_o,
    output logic              par_o,
    output logic              err_o,
    output logic              val_o
);
    rd_state_t state_q;
    rd_state_t state_d;
    logic      enb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            enb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            enb_q   <= !enb_n_i;
        end
    end

    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        if (!sel_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_XFER;
                ST_XFER: begin
                    if (enb_q) begin
                        if (fifo_empty) begin
                            state_d = ST_HOLD;
                        end else begin
                            pop = 1'b1;
                            if (head.eop) state_d = ST_EOP;
                        end
                    end
                end
                ST_EOP:  if (enb_q) state_d = ST_HOLD;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_o  <= 1'b0;
            data_o <= '0;
            sop_o  <= 1'b0;
            eop_o  <= 1'b0;
            mod_o  <= '0;
            par_o  <= 1'b1;
            err_o  <= 1'b0;
        end else begin
            if (!sel_i) begin
                val_o <= 1'b0;
            end else if (enb_q) begin
                val_o <= pop;
            end
            if (pop) begin
                data_o <= head.data;
                sop_o  <= head.sop;
                eop_o  <= head.eop;
                mod_o  <= head.eop ? head.mod : '0;
                err_o  <= head.eop && head.err;
                par_o  <= head_par;
            end
        end
    end

    assert_valid_stays_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && sel_i) |=> !val_o);

    assert_eop_then_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOP && enb_q && sel_i) |=> !val_o);

    assert_hold_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enb_q && sel_i) |=> ($stable(data_o) && $stable(val_o) && $stable(eop_o)));

    assert_no_pop_while_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q != ST_IDLE) |-> (state_q == ST_XFER));
endmodule

// File: rtl/pos_rx_port.sv
module pos_rx_port
    import pos_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [MOD_W-1:0]  wr_mod,
    input  logic              wr_err,
    output logic              arr_ts,
    output logic              ovf_sticky,
    input  logic              sel,
    input  logic              rd_enb_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic [MOD_W-1:0]  rd_mod,
    output logic              rd_par,
    output logic              rd_err,
    output logic              rd_val
);
    rx_word_t wr_word;
    rx_word_t head;
    logic     full;
    logic     empty;
    logic     pop;
    logic     head_par;

    assign wr_word = '{sop: wr_sop, eop: wr_eop, mod: wr_mod, err: wr_err, data: wr_data};

    pos_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .din   (wr_word),
        .pop   (pop),
        .head  (head),
        .full  (full),
        .empty (empty)
    );

    pos_rx_parity #(.W(DATA_W)) par_i (
        .data    (head.data),
        .odd_bit (head_par)
    );

    pos_rx_rdctl rdctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .enb_n_i    (rd_enb_n),
        .fifo_empty (empty),
        .head       (head),
        .head_par   (head_par),
        .pop        (pop),
        .data_o     (rd_data),
        .sop_o      (rd_sop),
        .eop_o      (rd_eop),
        .mod_o      (rd_mod),
        .par_o      (rd_par),
        .err_o      (rd_err),
        .val_o      (rd_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_ts     <= 1'b0;
            ovf_sticky <= 1'b0;
        end else begin
            arr_ts     <= wr_en && !full && wr_sop;
            ovf_sticky <= ovf_sticky || (wr_en && full);
        end
    end

    assert_err_needs_eop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_val && rd_err) |-> rd_eop);

    assert_parity_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_val |-> (^{rd_data, rd_par}) == 1'b1);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    assert_arrival_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_ts) |-> $past(wr_en && wr_sop));
endmodule

// File: tb/pos_rx_port_tb_top.sv
module pos_rx_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        wr_sop;
    logic        wr_eop;
    logic [1:0]  wr_mod;
    logic        wr_err;
    logic        arr_ts;
    logic        ovf_sticky;
    logic        sel;
    logic        rd_enb_n;
    logic [31:0] rd_data;
    logic        rd_sop;
    logic        rd_eop;
    logic [1:0]  rd_mod;
    logic        rd_par;
    logic        rd_err;
    logic        rd_val;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // model entry: {sop, eop, mod[1:0], err, data[31:0]}
    logic [36:0] model_q [$];

    always #10 clk = ~clk;

    pos_rx_port dut_i (.*);

    function automatic logic exp_par(input logic [31:0] d);
        return ~(^d);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d, input logic s, input logic e,
                              input logic [1:0] m, input logic er);
        bit acc;
        acc = (model_q.size() < 64);
        wr_en = 1'b1; wr_data = d; wr_sop = s; wr_eop = e; wr_mod = m; wr_err = er;
        @(negedge clk);
        wr_en = 1'b0;
        if (acc) model_q.push_back({s, e, m, er, d});
        check("R9 arrival pulse", 64'(arr_ts), 64'(acc && s));
    endtask

    task automatic write_packet(input int len);
        for (int i = 0; i < len; i++) begin
            write_word($urandom, i == 0, i == len - 1, 2'($urandom), 1'($urandom));
        end
    endtask

    task automatic check_word(input string req);
        logic [36:0] w;
        logic        e;
        w = model_q.pop_front();
        e = w[35];
        check({req, " valid"}, 64'(rd_val), 64'd1);
        check({req, " data"}, 64'(rd_data), 64'(w[31:0]));
        check({req, " sop"}, 64'(rd_sop), 64'(w[36]));
        check({req, " eop"}, 64'(rd_eop), 64'(e));
        check("R12 mod", 64'(rd_mod), 64'(e ? w[34:33] : 2'b00));
        check("R4 err", 64'(rd_err), 64'(e & w[32]));
        check("R3 parity", 64'(rd_par), 64'(exp_par(w[31:0])));
    endtask

    task automatic reselect();
        sel = 1'b0;
        @(negedge clk);
        sel = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_stream();
        bit last;
        reselect();
        rd_enb_n = 1'b0;
        @(negedge clk);
        check("R2 no word before latency", 64'(rd_val), 64'd0);
        last = 1'b0;
        while (!last && model_q.size() > 0) begin
            last = model_q[0][35];
            @(negedge clk);
            check_word("R2 R11 stream");
        end
        @(negedge clk);
        check("R6 valid low after eop", 64'(rd_val), 64'd0);
        @(negedge clk);
        check("R6 stays low", 64'(rd_val), 64'd0);
        rd_enb_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_sop = 1'b0; wr_eop = 1'b0;
        wr_mod = '0; wr_err = 1'b0; sel = 1'b0; rd_enb_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid", 64'(rd_val), 64'd0);
        check("R1 arr_ts", 64'(arr_ts), 64'd0);
        check("R1 ovf", 64'(ovf_sticky), 64'd0);

        // directed: masking on middle word
        write_word(32'h1234_5678, 1'b1, 1'b0, 2'd2, 1'b1);
        write_word(32'h0000_0001, 1'b0, 1'b0, 2'd3, 1'b1);
        write_word(32'hFFFF_0000, 1'b0, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        check("R9 single pulse", 64'(arr_ts), 64'd0);
        sel = 1'b1;
        @(negedge clk);
        rd_enb_n = 1'b0;
        @(negedge clk);
        rd_enb_n = 1'b1;
        check("R2 latency", 64'(rd_val), 64'd0);
        @(negedge clk);
        check_word("R2 first word");
        repeat (3) @(negedge clk);
        check("R8 hold valid", 64'(rd_val), 64'd1);
        check("R8 hold data", 64'(rd_data), 64'h1234_5678);
        rd_enb_n = 1'b0;
        @(negedge clk);
        check("R8 hold at enable", 64'(rd_data), 64'h1234_5678);
        @(negedge clk);
        check_word("R4 R12 mid word");
        @(negedge clk);
        check_word("R4 R12 eop word");
        @(negedge clk);
        check("R6 valid low", 64'(rd_val), 64'd0);
        rd_enb_n = 1'b1;

        // random packets
        for (int p = 0; p < 20; p++) begin
            write_packet(1 + int'($urandom_range(7)));
            read_stream();
        end

        // empty FIFO: latch low, then new data must not leak out
        reselect();
        rd_enb_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 empty valid", 64'(rd_val), 64'd0);
        rd_enb_n = 1'b1;
        write_packet(3);
        rd_enb_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 R7 still low", 64'(rd_val), 64'd0);
        rd_enb_n = 1'b1;
        read_stream();

        // overflow
        for (int i = 0; i < 66; i++) begin
            write_word(32'hA000_0000 + 32'(i), i == 0, i == 63, 2'd1, 1'b0);
        end
        check("R10 ovf set", 64'(ovf_sticky), 64'd1);
        check("R10 depth held", 64'(model_q.size()), 64'd64);
        read_stream();
        check("R10 model drained", 64'(model_q.size()), 64'd0);
        repeat (2) @(negedge clk);
        check("R10 ovf sticky", 64'(ovf_sticky), 64'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule